// File: doc/BRIEF.md
# CIC Decimator with Pruned Comb Section

This block lowers the sample rate of a signed stream by an integer factor using a cascaded integrator-comb structure. A chain of integrators runs at the input rate and accepts one sample in every cycle that the input valid is high. A modulo counter picks one integrator result out of every `RATE` accepted samples and passes it to a chain of first-order comb stages. The combs run only on those picked samples.

All word growth is held in the integrator registers. Their width is the input width plus `STAGES * ceil(log2(RATE))`, and they wrap freely in two's complement. Each comb stage takes the difference at its own input width, wrapping there, and then discards one least significant bit by arithmetic floor. The result is `STAGES` bits narrower than the integrators. A gap in the input valid freezes the whole high-rate side, so a bursty source produces the same output sequence as a continuous one.

Top module: `cic_decim`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_valid` is 0 and `out_data` is 0. All integrator, counter and comb state starts from zero.
- R2: On each accepted sample, the first integrator adds the sign-extended input. Integrator k (k >= 1) adds the value that integrator k-1 held before that edge. All integrators are `IN_W + STAGES*ceil(log2(RATE))` bits wide and wrap in two's complement.
- R3: A counter counts accepted samples modulo `RATE`, starting from 0 at reset. The sample that arrives while the counter reads `RATE-1` is kept, so the `RATE`-th accepted sample after reset is kept, and every `RATE`-th one after that. The value passed on is the last integrator's value after that sample has been added.
- R4: `out_valid` is a single-cycle pulse that rises exactly `STAGES` clock edges after the edge that accepted a kept sample. There is exactly one pulse for each kept sample and no other pulse.
- R5: Comb stage k (k = 0 first) has input width `W-k`, where W is the integrator width. It forms input minus its previous input, wrapped to `W-k` bits, and emits that difference shifted right arithmetically by one bit. `out_data` is the last stage's result, `W-STAGES` bits wide.
- R6: A cycle with `in_valid` low changes neither the integrators nor the counter, and produces no output pulse of its own.
- R7: For a constant input c held long enough to settle, `out_data` is within 2 of `c * RATE^STAGES / 2^STAGES`, which is 512c with the default parameters.
- R8: A constant input at the positive full scale `2^(IN_W-1)-1` settles to a positive output within 2 of `(2^(IN_W-1)-1) * RATE^STAGES / 2^STAGES`, with no wrap at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_data` carries a sample to accept |
| in_data | input | IN_W | Signed high-rate input sample |
| out_valid | output | 1 | One-cycle pulse marking a low-rate output |
| out_data | output | IN_W+STAGES*ceil(log2(RATE))-STAGES | Signed decimated result, held between pulses |

## Verification
Two things can happen in the same cycle: the integrators take a new input sample, and the comb pipeline finishes a result or the next kept value is latched into the first comb. The bench provokes this by keeping `in_valid` high through whole runs of samples, so every kept value is read from the last integrator while that integrator is already absorbing the following sample. Each emitted result is judged against an independent bit-exact model of the wrap and floor arithmetic, together with its pulse cycle. Runs with random gaps in `in_valid` check that the held state stays exact when the two sides fall out of step.

// File: rtl/cic_decim_pkg.sv
package cic_decim_pkg;

  // Integrator width: input plus worst-case growth of STAGES integrators over RATE samples
  function automatic int int_width(int in_w, int stages, int rate);
    return in_w + stages * $clog2(rate);
  endfunction

  // Input width of comb stage k; each earlier stage removed one LSB
  function automatic int comb_in_width(int acc_w, int k);
    return acc_w - k;
  endfunction

  // Final output width after all comb stages pruned one bit each
  function automatic int out_width(int in_w, int stages, int rate);
    return int_width(in_w, stages, rate) - stages;
  endfunction

endpackage

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int IN_W   = 8,
  parameter int STAGES = 3,
  parameter int ACC_W  = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic signed [ACC_W-1:0] acc_last
);

  localparam int EXT_W = ACC_W - IN_W;

  for (genvar k = 0; k < STAGES; k++) begin : g_acc
    logic signed [ACC_W-1:0] addend;
    logic signed [ACC_W-1:0] acc_q;

    if (k == 0) begin : g_head
      assign addend = {{EXT_W{in_data[IN_W-1]}}, in_data};
    end else begin : g_tail
      // pipelined form: add the previous stage's registered value
      assign addend = g_acc[k-1].acc_q;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q <= '0;
      end else if (in_valid) begin
        acc_q <= acc_q + addend;  // wraps modulo 2^ACC_W by design
      end
    end
  end

  assign acc_last = g_acc[STAGES-1].acc_q;

endmodule

// File: rtl/cic_decim_sel.sv
module cic_decim_sel #(
  parameter  int RATE  = 16,
  localparam int CNT_W = $clog2(RATE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic [CNT_W-1:0] cnt,
  output logic             keep,
  output logic             keep_q
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(RATE - 1);

  assign keep = in_valid && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      keep_q <= 1'b0;
    end else begin
      keep_q <= keep;
      if (in_valid) begin
        cnt <= keep ? '0 : cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/cic_comb_stage.sv
module cic_comb_stage #(
  parameter int DW = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] din,
  output logic                 out_valid,
  output logic signed [DW-2:0] dout
);

  logic signed [DW-1:0] prev_q;
  logic signed [DW-1:0] diff;
  logic                 unused_lsb;

  assign diff       = din - prev_q;  // modulo 2^DW
  assign unused_lsb = diff[0];       // pruned bit

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      dout      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        prev_q <= din;
        dout   <= diff[DW-1:1];
      end
    end
  end

endmodule

// File: rtl/cic_decim.sv
module cic_decim
  import cic_decim_pkg::*;
#(
  parameter  int IN_W   = 8,
  parameter  int STAGES = 3,
  parameter  int RATE   = 16,
  localparam int INT_W  = int_width(IN_W, STAGES, RATE),
  localparam int OUT_W  = out_width(IN_W, STAGES, RATE)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  localparam int CNT_W = $clog2(RATE);

  // internal events, named for the checker
  logic signed [INT_W-1:0] int_last;
  logic [CNT_W-1:0]        sel_cnt;
  logic                    keep_evt;
  logic                    keep_q;

  cic_integ_chain #(
    .IN_W  (IN_W),
    .STAGES(STAGES),
    .ACC_W (INT_W)
  ) u_integ (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_data (in_data),
    .acc_last(int_last)
  );

  cic_decim_sel #(
    .RATE(RATE)
  ) u_sel (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .cnt     (sel_cnt),
    .keep    (keep_evt),
    .keep_q  (keep_q)
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_comb
    localparam int CW = comb_in_width(INT_W, k);
    logic signed [CW-1:0] din;
    logic                 din_vld;
    logic signed [CW-2:0] dout;
    logic                 dout_vld;

    if (k == 0) begin : g_first
      assign din     = int_last;
      assign din_vld = keep_q;
    end else begin : g_next
      assign din     = g_comb[k-1].dout;
      assign din_vld = g_comb[k-1].dout_vld;
    end

    cic_comb_stage #(
      .DW(CW)
    ) u_stage (
      .clk      (clk),
      .rst      (rst),
      .in_valid (din_vld),
      .din      (din),
      .out_valid(dout_vld),
      .dout     (dout)
    );
  end

  assign out_data  = g_comb[STAGES-1].dout;
  assign out_valid = g_comb[STAGES-1].dout_vld;

endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk #(
  parameter int STAGES = 3,
  parameter int RATE   = 16,
  parameter int W      = 20
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     keep_evt,
  input logic [$clog2(RATE)-1:0]  sel_cnt,
  input logic signed [W-1:0]      int_last,
  input logic                     out_valid
);

  // tracks kept samples through the comb latency, one bit per edge
  logic [STAGES:0] trk_q;

  always_ff @(posedge clk) begin
    if (rst) trk_q <= '0;
    else     trk_q <= {trk_q[STAGES-1:0], keep_evt};
  end

  // R3: counter restarts after a kept sample
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    keep_evt |=> (sel_cnt == '0));

  // R6: idle cycle leaves integrators and counter untouched
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(int_last) && $stable(sel_cnt)));

  // R4: output pulse lines up with a kept sample STAGES edges earlier
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == trk_q[STAGES]);

  // R4: pulse lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

endmodule

bind cic_decim cic_decim_chk #(
  .STAGES(STAGES),
  .RATE  (RATE),
  .W     (INT_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .keep_evt (keep_evt),
  .sel_cnt  (sel_cnt),
  .int_last (int_last),
  .out_valid(out_valid)
);

// File: tb/cic_decim_tb_top.sv
module cic_decim_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 8;
  localparam int N    = 3;
  localparam int R    = 16;
  localparam int W    = IN_W + N * $clog2(R);
  localparam int OW   = W - N;
  localparam longint DC_GAIN = (longint'(R) ** N) >>> N;

  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic signed [IN_W-1:0] in_data;
  logic out_valid;
  logic signed [OW-1:0] out_data;

  cic_decim #(.IN_W(IN_W), .STAGES(N), .RATE(R)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // expected outputs
  longint eq_val [256];
  longint eq_cyc [256];
  int wr_i = 0;
  int rd_i = 0;
  longint last_out = 0;
  int out_seen = 0;

  // reference model state
  longint mi [N];
  longint mc [N];
  int mcnt = 0;

  function automatic longint wrapw(longint v, int w);
    longint m = longint'(1) <<< w;
    longint r = v & (m - 1);
    if (r >= (m >>> 1)) r = r - m;
    return r;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < N; k++) begin mi[k] = 0; mc[k] = 0; end
    mcnt = 0; wr_i = 0; rd_i = 0;
  endtask

  task automatic model_step(longint x);
    longint old [N];
    longint v;
    for (int k = 0; k < N; k++) old[k] = mi[k];
    mi[0] = wrapw(mi[0] + x, W);
    for (int k = 1; k < N; k++) mi[k] = wrapw(mi[k] + old[k-1], W);
    if (mcnt == R - 1) begin
      v = mi[N-1];
      for (int k = 0; k < N; k++) begin
        longint d = wrapw(v - mc[k], W - k);
        mc[k] = v;
        v = d >>> 1;
      end
      eq_val[wr_i % 256] = v;
      eq_cyc[wr_i % 256] = cyc + 1 + N;
      wr_i++;
      mcnt = 0;
    end else begin
      mcnt++;
    end
  endtask

  task automatic drive(bit v, longint x);
    @(negedge clk);
    in_valid = v;
    in_data  = IN_W'(x);
    if (v) model_step(wrapw(x, IN_W));
  endtask

  task automatic drain();
    repeat (N + 3) drive(0, 0);
  endtask

  // output monitor: R4 timing and R5 value
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (rd_i == wr_i) begin
        chk(0, "R4 pulse with no kept sample", 1, 0);
      end else begin
        chk(longint'(out_data) == eq_val[rd_i % 256], "R5 output value",
            longint'(out_data), eq_val[rd_i % 256]);
        chk(cyc == eq_cyc[rd_i % 256], "R4 output cycle", cyc, eq_cyc[rd_i % 256]);
        rd_i++;
      end
      last_out = longint'(out_data);
      out_seen++;
    end
  end

  task automatic t_reset();
    rst = 1; in_valid = 0; in_data = '0;
    repeat (4) @(posedge clk);
    model_reset();
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    chk(out_data == 0, "R1 out_data in reset", out_data, 0);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid after release", out_valid, 0);
    chk(out_data == 0, "R1 out_data after release", out_data, 0);
  endtask

  // R2 R3 R5: continuous ramp, outputs emerge while inputs keep arriving
  task automatic t_ramp();
    int s0 = out_seen;
    for (int i = 0; i < 10 * R; i++) drive(1, (i * 37) - 90);
    drain();
    chk(out_seen - s0 == 10, "R3 one output per RATE samples", out_seen - s0, 10);
    chk(rd_i == wr_i, "R2 all kept samples emitted", rd_i, wr_i);
  endtask

  // R5: alternating full-scale input stresses the comb wraps
  task automatic t_alt();
    for (int i = 0; i < 6 * R; i++) drive(1, (i % 2 == 0) ? 127 : -128);
    drain();
    chk(rd_i == wr_i, "R5 alternating outputs emitted", rd_i, wr_i);
  endtask

  // R6: random gaps in in_valid, then a long idle window
  task automatic t_gaps();
    logic [7:0] lfsr = 8'hA5;
    int sent = 0;
    int s0;
    while (sent < 8 * R) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[0] || lfsr[2]) begin
        drive(1, (sent * 13) - 60);
        sent++;
      end else begin
        drive(0, 99);
      end
    end
    drain();
    s0 = out_seen;
    repeat (40) drive(0, 77);
    chk(out_seen == s0, "R6 no output while idle", out_seen - s0, 0);
    chk(rd_i == wr_i, "R6 gapped outputs emitted", rd_i, wr_i);
  endtask

  // R7 / R8: constant input settles to c*R^N/2^N
  task automatic t_dc(longint c, string req);
    longint exp = c * DC_GAIN;
    longint dlt;
    for (int i = 0; i < 8 * R; i++) drive(1, c);
    drain();
    dlt = last_out - exp;
    chk((dlt <= 2) && (dlt >= -2), req, last_out, exp);
    if (c > 0) chk(last_out > 0, req, last_out, exp);
  endtask

  initial begin
    t_reset();
    t_ramp();
    t_alt();
    t_gaps();
    t_dc(50, "R7 DC gain");
    t_dc(-37, "R7 DC gain negative");
    t_dc(127, "R8 positive full scale");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule